// File: doc/BRIEF.md
# Bidirectional GPIO Port with Peripheral Override

This block is a parameterised parallel I/O port. Each pin has a direction bit, an output latch bit and a synchronised pin level. Software reaches all three through a small synchronous register bus with address, write enable, write data, read enable and registered read data. On the pad side each bit drives an output value and an output enable, and it receives a pad input.

Every bit also has a peripheral interface made of enable, drive-active and output value. A peripheral that is enabled and actively driving takes that bit's pad output away from the port. The pin level can still be read through the port register. A mask parameter states which bits exist. Bits outside the mask have no storage, always read as zero and never drive the pad.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction register reads back the implemented-bit mask (every implemented pin is an input), the latch register reads zero, and every pad output enable is low.
- R2: For a bit the peripheral does not own, direction 0 sets pad_oe high and direction 1 sets it low. pad_out always carries the latch bit.
- R3: A read of the latch register (offset 2) returns the stored latch, whatever the pad input level is.
- R4: A write to the port register (offset 1) updates the latch, exactly as a write to offset 2 does. The new value is visible through a latch read and on pad_out.
- R5: A read of the port register returns pad_in after a two-flop synchroniser. The pad level becomes visible once two clock edges have passed.
- R6: When per_en and per_drive are both 1 for an implemented bit, pad_oe for that bit is 1 and pad_out equals per_out, whatever the direction and latch bits hold.
- R7: When per_en is 1 but per_drive is 0, the bit's pad output follows the port's direction and latch as in R2.
- R8: The port register returns the pad level both while the peripheral owns the output and while the port owns it.
- R9: For bits outside IMPL_MASK, all registers read zero, writes have no effect, and pad_oe and pad_out stay 0.
- R10: The direction register is at offset 0. Read data appears one cycle after reg_re is asserted. reg_rdata is zero in a cycle following one with reg_re low, and a read of offset 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register offset |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | WIDTH | Write data |
| reg_re | input | 1 | Register read enable |
| reg_rdata | output | WIDTH | Read data, one cycle after reg_re |
| pad_in | input | WIDTH | Pad input levels |
| pad_out | output | WIDTH | Pad output values |
| pad_oe | output | WIDTH | Pad output enables |
| per_en | input | WIDTH | Peripheral enabled, per bit |
| per_drive | input | WIDTH | Peripheral actively driving, per bit |
| per_out | input | WIDTH | Peripheral output value, per bit |

## Verification
The bench builds the port with WIDTH = 8 and IMPL_MASK = 8'hB7, so two bits in the middle of the vector are missing. This choice lets every 8-bit write pattern be swept through the direction, port and latch registers. The absent bits are therefore probed with all data values, and the expected masking is computed arithmetically. Sweeps of the peripheral enable and drive patterns against fixed latch and direction settings cover every ownership case for each bit.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int unsigned OFS_DIR  = 0;
    localparam int unsigned OFS_PORT = 1;
    localparam int unsigned OFS_LAT  = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int unsigned       WIDTH     = 8,
    parameter logic [WIDTH-1:0] IMPL_MASK = '1
) (
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] lat,
    input  logic [WIDTH-1:0] per_en,
    input  logic [WIDTH-1:0] per_drive,
    input  logic [WIDTH-1:0] per_out,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        if (IMPL_MASK[b]) begin : g_impl
            logic take;
            assign take       = per_en[b] & per_drive[b];
            assign pad_out[b] = take ? per_out[b] : lat[b];
            assign pad_oe[b]  = take ? 1'b1 : ~dir[b];
        end else begin : g_absent
            assign pad_out[b] = 1'b0;
            assign pad_oe[b]  = 1'b0;
        end
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int unsigned       WIDTH     = 8,
    parameter int unsigned       ADDR_W    = 2,
    parameter logic [WIDTH-1:0] IMPL_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [WIDTH-1:0]  reg_wdata,
    input  logic              reg_re,
    input  logic [WIDTH-1:0]  pin_sync,
    output logic [WIDTH-1:0]  reg_rdata,
    output logic [WIDTH-1:0]  dir,
    output logic [WIDTH-1:0]  lat
);
    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] lat;
        logic [WIDTH-1:0] rdata;
    } regs_t;

    regs_t st_d, st_q;
    logic [WIDTH-1:0] sel;

    always_comb begin
        st_d = st_q;
        unique case (int'(reg_addr))
            OFS_DIR:  sel = st_q.dir;
            OFS_PORT: sel = pin_sync;
            OFS_LAT:  sel = st_q.lat;
            default:  sel = '0;
        endcase
        st_d.rdata = reg_re ? (sel & IMPL_MASK) : '0;
        if (reg_we) begin
            if (int'(reg_addr) == OFS_DIR)
                st_d.dir = reg_wdata & IMPL_MASK;
            if (int'(reg_addr) == OFS_PORT || int'(reg_addr) == OFS_LAT)
                st_d.lat = reg_wdata & IMPL_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.dir   <= IMPL_MASK;
            st_q.lat   <= '0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata = st_q.rdata;
    assign dir       = st_q.dir;
    assign lat       = st_q.lat;
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
    parameter int unsigned       WIDTH     = 8,
    parameter int unsigned       ADDR_W    = 2,
    parameter logic [WIDTH-1:0] IMPL_MASK = 8'hB7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [WIDTH-1:0]  reg_wdata,
    input  logic              reg_re,
    output logic [WIDTH-1:0]  reg_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    input  logic [WIDTH-1:0]  per_en,
    input  logic [WIDTH-1:0]  per_drive,
    input  logic [WIDTH-1:0]  per_out
);
    logic [WIDTH-1:0] pin_sync, dir, lat;

    gpio_sync #(.WIDTH(WIDTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pin_sync)
    );

    gpio_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .IMPL_MASK(IMPL_MASK)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_re(reg_re), .pin_sync(pin_sync),
        .reg_rdata(reg_rdata), .dir(dir), .lat(lat)
    );

    gpio_pad_mux #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_mux (
        .dir(dir), .lat(lat), .per_en(per_en), .per_drive(per_drive),
        .per_out(per_out), .pad_out(pad_out), .pad_oe(pad_oe)
    );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int unsigned       WIDTH     = 8,
    parameter int unsigned       ADDR_W    = 2,
    parameter logic [WIDTH-1:0] IMPL_MASK = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_re,
    input logic [WIDTH-1:0]  reg_rdata,
    input logic [WIDTH-1:0]  pad_out,
    input logic [WIDTH-1:0]  pad_oe,
    input logic [WIDTH-1:0]  per_en,
    input logic [WIDTH-1:0]  per_drive,
    input logic [WIDTH-1:0]  per_out
);
    // R9
    absent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | pad_out | reg_rdata) & ~IMPL_MASK) == '0);
    // R6
    takeover_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (per_en & per_drive & IMPL_MASK & ~pad_oe) == '0);
    // R6
    takeover_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out ^ per_out) & per_en & per_drive & IMPL_MASK) == '0);
    // R10
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re |=> reg_rdata == '0);
    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && int'(reg_addr) == 3) |=> reg_rdata == '0);
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .IMPL_MASK(IMPL_MASK)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_re(reg_re),
    .reg_rdata(reg_rdata), .pad_out(pad_out), .pad_oe(pad_oe),
    .per_en(per_en), .per_drive(per_drive), .per_out(per_out)
);

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
    localparam int unsigned W = 8;
    localparam logic [W-1:0] M = 8'hB7;

    logic clk = 0, rst_n = 0;
    logic [1:0] reg_addr = 0;
    logic reg_we = 0, reg_re = 0;
    logic [W-1:0] reg_wdata = 0, reg_rdata, pad_in = 0, pad_out, pad_oe;
    logic [W-1:0] per_en = 0, per_drive = 0, per_out = 0;
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_port #(.WIDTH(W), .ADDR_W(2), .IMPL_MASK(M)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(reg_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .per_en(per_en), .per_drive(per_drive), .per_out(per_out)
    );

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [W-1:0] d);
        @(negedge clk);
        reg_addr = 2'(a); reg_wdata = d; reg_we = 1;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(int a, output logic [W-1:0] d);
        @(negedge clk);
        reg_addr = 2'(a); reg_re = 1;
        @(negedge clk);
        reg_re = 0;
        d = reg_rdata;
    endtask

    function automatic logic [W-1:0] exp_oe(logic [W-1:0] dir, logic [W-1:0] en,
                                           logic [W-1:0] drv);
        logic [W-1:0] t = en & drv;
        return (t | (~dir & ~t)) & M;
    endfunction

    function automatic logic [W-1:0] exp_out(logic [W-1:0] lat, logic [W-1:0] en,
                                            logic [W-1:0] drv, logic [W-1:0] po);
        logic [W-1:0] t = en & drv;
        return ((t & po) | (~t & lat)) & M;
    endfunction

    initial begin
        logic [W-1:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 oe", pad_oe, '0);
        rd(0, r); check("R1 dir", r, M);
        rd(2, r); check("R1 lat", r, '0);
        // R10 idle read gives zero
        @(negedge clk); check("R10 idle", reg_rdata, '0);

        // R2 R9 R10: direction sweep over all values
        for (int v = 0; v < 256; v++) begin
            wr(0, W'(v));
            rd(0, r); check("R10 R9 dir", r, W'(v) & M);
            check("R2 oe", pad_oe, exp_oe(W'(v), '0, '0));
        end
        // R3 R4 R9: latch via both offsets, pad_in set to complement
        for (int v = 0; v < 256; v++) begin
            pad_in = ~W'(v);
            wr((v % 2 == 0) ? 1 : 2, W'(v));
            rd(2, r); check("R3 R4 R9 lat", r, W'(v) & M);
            check("R2 R4 out", pad_out, W'(v) & M);
        end
        // R10 unmapped offset
        rd(3, r); check("R10 unmapped", r, '0);

        // R5: pad input sweep through synchroniser
        for (int v = 0; v < 256; v++) begin
            @(negedge clk); pad_in = W'(v);
            repeat (2) @(negedge clk);
            rd(1, r); check("R5 port", r, W'(v) & M);
        end

        // R6 R7 R8: ownership sweep
        wr(0, 8'h0F);
        wr(2, 8'h55);
        for (int e = 0; e < 16; e++) begin
            for (int d = 0; d < 16; d++) begin
                @(negedge clk);
                per_en    = {W'(e)} * 8'h11;
                per_drive = {W'(d)} * 8'h11;
                per_out   = W'(e * 16 + d) ^ 8'hA3;
                pad_in    = W'(e * 7 + d * 13);
                #1;
                check("R6 R7 oe", pad_oe, exp_oe(8'h0F, per_en, per_drive));
                check("R6 R7 out", pad_out, exp_out(8'h55, per_en, per_drive, per_out));
                repeat (2) @(negedge clk);
                rd(1, r); check("R8 port", r, W'(e * 7 + d * 13) & M);
            end
        end
        per_en = 0; per_drive = 0;
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule